// File: doc/BRIEF.md
# Trap Entry and Processor Status Control

This block keeps the privilege/interrupt level of the processor and the registers a trap handler needs when it starts: the level that was interrupted, the address to resume or retry from, the faulting memory address with its cause, one scratch word and a running count of memory operations. A 4-bit level lives in bits 31..28 of the status word. The level that was in force before the last trap or interrupt lives in bits 27..24.

When an instruction trap or an accepted interrupt arrives, the block moves the level into the old-level field and drops the level to zero in the same clock edge. Level zero turns off interrupts and address translation and permits privileged instructions. Software running at a permitted level reads and writes every register through one select/data port. The block derives three enables from the level: translation on, interrupts on and privileged instructions allowed. A trap always beats an interrupt. An interrupt that cannot be taken is held until the level allows it.

Top module: `trap_status_ctl`

## Requirements
- R1: Reset sets level and old-level to 0 and clears the trap PC, trap address, save register, counter and pending interrupt. After reset, `mmu_en`=0, `int_en`=0 and `priv_ok`=1.
- R2: On an instruction trap or an accepted interrupt, old-level takes the current level and the level becomes 0 at the same clock edge.
- R3: The status word reads as level in bits 31..28, old-level in 27..24 and zero elsewhere. `mmu_en` is level bit 3. `int_en` is 1 when the level is nonzero. `priv_ok` is 0 only at level 15.
- R4: An instruction trap loads the trap PC from `cur_pc`. An accepted interrupt loads it from `next_pc`.
- R5: A trap with `trap_mem`=1 loads the trap address register with `fault_addr[31:2]` in bits 31..2. Bits 1..0 take `fault_cause` if `mmu_en` was 1, and 0 otherwise. Cause codes are 00 invalid, 01 no-execute, 10 no-write, 11 no-read. A trap with `trap_mem`=0 and an interrupt leave the register unchanged.
- R6: Each cycle the counter adds the number of asserted strobes among `op_fetch`, `op_load` and `op_store`, wrapping modulo 2^32.
- R7: An interrupt is accepted only when `int_en`=1 and no trap is requested in that cycle. Otherwise it stays pending and is accepted in the first cycle both conditions hold. After acceptance it is cleared.
- R8: Register select codes are: 0 status, 1 trap PC, 2 trap address, 3 save, 4 counter. Other codes read 0. Reads are combinational. A write takes effect at the next clock edge.
- R9: Writes are ignored while `priv_ok`=0.
- R10: In the same cycle, a trap overrides a status, trap PC or trap address write, and a counter write overrides the strobe increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Instruction trap strobe |
| trap_mem | input | 1 | The trap is a memory fault |
| fault_addr | input | 32 | Faulting memory address |
| fault_cause | input | 2 | Memory fault cause code |
| irq_req | input | 1 | Interrupt request strobe |
| cur_pc | input | 32 | Address of the current instruction |
| next_pc | input | 32 | Address of the next instruction |
| op_fetch | input | 1 | Instruction fetch strobe |
| op_load | input | 1 | Operand load strobe |
| op_store | input | 1 | Operand store strobe |
| reg_sel | input | 3 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register contents |
| mmu_en | output | 1 | Address translation enabled |
| int_en | output | 1 | Interrupts enabled |
| priv_ok | output | 1 | Privileged instructions permitted |

## Verification
Trap entry is driven from a level with bit 3 set and from level 0. This shows whether the cause bits follow the translation state, and whether old-level keeps the value that was actually interrupted. A memory fault, an instruction trap and an interrupt are each applied, telling apart which of the two PCs is captured and whether the trap address register is touched. An interrupt is raised at level 0 and together with a trap; the level is then raised to show deferred acceptance happens exactly once. The counter is driven with three simultaneous strobes across the wrap point, with a single strobe, and together with a write.

// File: rtl/trap_status_ctl.sv
module trap_status_ctl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        trap_req,
  input  logic        trap_mem,
  input  logic [31:0] fault_addr,
  input  logic [1:0]  fault_cause,
  input  logic        irq_req,
  input  logic [31:0] cur_pc,
  input  logic [31:0] next_pc,
  input  logic        op_fetch,
  input  logic        op_load,
  input  logic        op_store,
  input  logic [2:0]  reg_sel,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mmu_en,
  output logic        int_en,
  output logic        priv_ok
);

  logic [3:0]  level, old_level;
  logic [31:0] tpc, tma, save, cnt;
  logic        irq_pend;

  assign mmu_en  = level[3];
  assign int_en  = level != 4'h0;
  assign priv_ok = level != 4'hF;

  wire       irq_any  = irq_req | irq_pend;
  wire       take_irq = irq_any & int_en & ~trap_req;
  wire       enter    = trap_req | take_irq;
  wire       wr_ok    = reg_wr & priv_ok;
  wire [1:0] n_ops    = {1'b0, op_fetch} + {1'b0, op_load} + {1'b0, op_store};

  always_comb begin
    case (reg_sel)
      3'd0:    reg_rdata = {level, old_level, 24'h0};
      3'd1:    reg_rdata = tpc;
      3'd2:    reg_rdata = tma;
      3'd3:    reg_rdata = save;
      3'd4:    reg_rdata = cnt;
      default: reg_rdata = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level     <= 4'h0;
      old_level <= 4'h0;
      tpc       <= 32'h0;
      tma       <= 32'h0;
      save      <= 32'h0;
      cnt       <= 32'h0;
      irq_pend  <= 1'b0;
    end else begin
      if (enter) begin
        old_level <= level;
        level     <= 4'h0;
      end else if (wr_ok && reg_sel == 3'd0) begin
        level     <= reg_wdata[31:28];
        old_level <= reg_wdata[27:24];
      end

      if (trap_req)                       tpc <= cur_pc;
      else if (take_irq)                  tpc <= next_pc;
      else if (wr_ok && reg_sel == 3'd1)  tpc <= reg_wdata;

      if (trap_req && trap_mem)           tma <= {fault_addr[31:2], mmu_en ? fault_cause : 2'b00};
      else if (wr_ok && reg_sel == 3'd2)  tma <= reg_wdata;

      if (wr_ok && reg_sel == 3'd3)       save <= reg_wdata;

      if (wr_ok && reg_sel == 3'd4)       cnt <= reg_wdata;
      else                                cnt <= cnt + {30'h0, n_ops};

      irq_pend <= irq_any & ~take_irq;
    end
  end

  assert_entry_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    enter |=> (level == 4'h0 && old_level == $past(level)));

  assert_trap_pc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> tpc == $past(cur_pc));

  assert_irq_pc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |=> tpc == $past(next_pc));

  assert_cause_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && trap_mem && !mmu_en) |=> tma[1:0] == 2'b00);

  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ok && reg_sel == 3'd4) |=> cnt == $past(cnt) + {30'h0, $past(n_ops)});

  assert_irq_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && trap_req) |=> irq_pend);

  assert_locked_save_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !priv_ok) |=> $stable(save));

endmodule

// File: tb/trap_status_ctl_bench.sv
`timescale 1ns/1ps
module trap_status_ctl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trap_req = 0, trap_mem = 0, irq_req = 0;
  logic [31:0] fault_addr = 0, cur_pc = 0, next_pc = 0, reg_wdata = 0;
  logic [1:0]  fault_cause = 0;
  logic        op_fetch = 0, op_load = 0, op_store = 0, reg_wr = 0;
  logic [2:0]  reg_sel = 0;
  logic [31:0] reg_rdata;
  logic        mmu_en, int_en, priv_ok;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  trap_status_ctl u_trap_status_ctl (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_mem(trap_mem),
    .fault_addr(fault_addr), .fault_cause(fault_cause), .irq_req(irq_req),
    .cur_pc(cur_pc), .next_pc(next_pc), .op_fetch(op_fetch), .op_load(op_load),
    .op_store(op_store), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mmu_en(mmu_en), .int_en(int_en), .priv_ok(priv_ok));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] v);
    reg_sel = s; #1; v = reg_rdata;
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    reg_sel = s; reg_wdata = d; reg_wr = 1; tick(); reg_wr = 0;
  endtask

  task automatic rchk(input string tag, input logic [2:0] s, input logic [31:0] exp);
    logic [31:0] v;
    rd(s, v); chk(tag, v, exp);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 5; i++) rchk("R1 register cleared", 3'(i), 32'h0);
    chk("R1 mmu_en", {31'h0, mmu_en}, 0);
    chk("R1 int_en", {31'h0, int_en}, 0);
    chk("R1 priv_ok", {31'h0, priv_ok}, 1);
  endtask

  task automatic t_regmap();
    wr(0, 32'hA5FF_FFFF);
    rchk("R3 R8 status layout", 0, 32'hA500_0000);
    chk("R3 mmu_en at A", {31'h0, mmu_en}, 1);
    chk("R3 int_en at A", {31'h0, int_en}, 1);
    chk("R3 priv_ok at A", {31'h0, priv_ok}, 1);
    wr(3, 32'h1234_5678); rchk("R8 save", 3, 32'h1234_5678);
    wr(1, 32'hCAFE_0000); rchk("R8 trap pc", 1, 32'hCAFE_0000);
    wr(2, 32'h0000_0F0F); rchk("R8 trap addr", 2, 32'h0000_0F0F);
    rchk("R8 unused code reads 0", 7, 32'h0);
  endtask

  task automatic t_mem_fault();
    trap_req = 1; trap_mem = 1; fault_addr = 32'h1234_5677; fault_cause = 2'b10; cur_pc = 32'h1000;
    tick(); trap_req = 0; trap_mem = 0;
    rchk("R2 level saved on fault", 0, 32'h0A00_0000);
    rchk("R4 fault pc", 1, 32'h1000);
    rchk("R5 addr with cause", 2, 32'h1234_5676);
    chk("R3 mmu off after trap", {31'h0, mmu_en}, 0);
    chk("R3 int off after trap", {31'h0, int_en}, 0);
    trap_req = 1; trap_mem = 1; fault_addr = 32'hFFFF_FFFF; fault_cause = 2'b11; cur_pc = 32'h1002;
    tick(); trap_req = 0; trap_mem = 0;
    rchk("R5 cause zero with mmu off", 2, 32'hFFFF_FFFC);
    rchk("R2 old level 0", 0, 32'h0);
    trap_req = 1; cur_pc = 32'h1004; fault_addr = 32'h5555_5555;
    tick(); trap_req = 0;
    rchk("R5 non-memory trap keeps addr", 2, 32'hFFFF_FFFC);
    rchk("R4 instruction trap pc", 1, 32'h1004);
  endtask

  task automatic t_irq();
    wr(0, 32'h3000_0000);
    irq_req = 1; next_pc = 32'h400; cur_pc = 32'h3FE;
    tick(); irq_req = 0;
    rchk("R2 irq entry status", 0, 32'h0300_0000);
    rchk("R4 irq pc is next pc", 1, 32'h400);
    rchk("R5 irq keeps addr", 2, 32'hFFFF_FFFC);
  endtask

  task automatic t_pending();
    irq_req = 1; next_pc = 32'h500;
    tick(); irq_req = 0;
    rchk("R7 irq blocked at level 0", 0, 32'h0300_0000);
    rchk("R7 pc untouched while blocked", 1, 32'h400);
    reg_sel = 0; reg_wdata = 32'h1000_0000; reg_wr = 1; next_pc = 32'h600;
    tick(); reg_wr = 0;
    rchk("R7 level raised first", 0, 32'h1000_0000);
    tick();
    rchk("R7 pending irq taken", 0, 32'h0100_0000);
    rchk("R7 pending irq pc", 1, 32'h600);
    wr(0, 32'h1000_0000); tick();
    rchk("R7 pending cleared after take", 0, 32'h1000_0000);
  endtask

  task automatic t_collide();
    trap_req = 1; irq_req = 1; cur_pc = 32'h200; next_pc = 32'h700;
    tick(); trap_req = 0; irq_req = 0;
    rchk("R7 trap wins status", 0, 32'h0100_0000);
    rchk("R7 trap wins pc", 1, 32'h200);
    reg_sel = 0; reg_wdata = 32'h5000_0000; reg_wr = 1; next_pc = 32'h800;
    tick(); reg_wr = 0;
    rchk("R7 level written", 0, 32'h5000_0000);
    tick();
    rchk("R7 deferred irq status", 0, 32'h0500_0000);
    rchk("R7 deferred irq pc", 1, 32'h800);
  endtask

  task automatic t_priv();
    wr(0, 32'hF000_0000);
    chk("R3 priv_ok at 15", {31'h0, priv_ok}, 0);
    chk("R3 int_en at 15", {31'h0, int_en}, 1);
    wr(3, 32'hDEAD_BEEF); rchk("R9 save locked", 3, 32'h1234_5678);
    wr(0, 32'h2000_0000); rchk("R9 status locked", 0, 32'hF000_0000);
    wr(4, 32'd55);        rchk("R9 counter locked", 4, 32'h0);
    trap_req = 1; cur_pc = 32'h900;
    tick(); trap_req = 0;
    rchk("R2 trap from 15", 0, 32'h0F00_0000);
    chk("R3 priv back", {31'h0, priv_ok}, 1);
  endtask

  task automatic t_counter();
    wr(4, 32'hFFFF_FFFE);
    op_fetch = 1; op_load = 1; op_store = 1;
    tick(); op_fetch = 0; op_store = 0;
    rchk("R6 three ops wrap", 4, 32'h1);
    tick(); op_load = 0;
    rchk("R6 single op", 4, 32'h2);
    reg_sel = 4; reg_wdata = 32'd100; reg_wr = 1; op_fetch = 1;
    tick(); reg_wr = 0; op_fetch = 0;
    rchk("R10 counter write wins", 4, 32'd100);
    tick();
    rchk("R6 idle holds", 4, 32'd100);
  endtask

  task automatic t_write_vs_trap();
    wr(0, 32'h9000_0000);
    reg_sel = 0; reg_wdata = 32'h7700_0000; reg_wr = 1; trap_req = 1; cur_pc = 32'hA00;
    tick(); reg_wr = 0; trap_req = 0;
    rchk("R10 trap beats status write", 0, 32'h0900_0000);
    rchk("R10 trap pc", 1, 32'hA00);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_regmap();
    t_mem_fault();
    t_irq();
    t_pending();
    t_collide();
    t_priv();
    t_counter();
    t_write_vs_trap();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule